// File: doc/BRIEF.md
# Temperature-Aware Refresh Scheduler

This block paces auto-refresh for a DRAM controller. A down-counting interval timer fires once per configured refresh period. Each firing adds one refresh to a small debt counter, and every refresh the command arbiter grants pays one back. When the case temperature is reported as high, the period is cut in half. The new period takes hold only when the timer next reloads. The same edge updates a flag that tells the mode-register logic to select the high-temperature self-refresh option.

The block also sequences self refresh. An entry request first drops the termination enable and waits a configured number of cycles. It then raises a self-refresh command request, but only while all banks report idle. While the device sits in self refresh, no refresh is requested and no command is allowed. On exit, two separate wait counts run: non-read commands are released after the shorter one, and reads and termination only after the longer one. All timing values are cycle counts on configuration inputs.

Top module: `refresh_sched`

## Requirements
- R1: After reset, owed_cnt is 0, ref_req, sr_req, in_self_refresh and hot_sr_en are 0, and cmd_ok, rd_ok and term_en are 1.
- R2: With high_temp low, owed_cnt rises by one every cfg_refi cycles while no grant is given.
- R3: With high_temp high, the period is floor(cfg_refi/2) cycles, and hot_sr_en reads 1.
- R4: A change of high_temp does not alter the interval in progress; it applies from the next reload, which is also the cycle in which hot_sr_en changes.
- R5: In normal operation ref_req is 1 exactly when owed_cnt is nonzero; each cycle with ref_gnt and ref_req high lowers owed_cnt by one, and a grant in the same cycle as a timer firing leaves owed_cnt unchanged.
- R6: owed_cnt saturates at 8; ref_urgent is 1 exactly when ref_req is 1 and owed_cnt is 8.
- R7: ref_gnt while ref_req is 0 has no effect on owed_cnt.
- R8: A one-cycle sr_enter pulse in normal operation drops term_en in the next cycle; sr_req first reads 1 cfg_aofd+2 cycles after the pulse cycle.
- R9: sr_req is 0 whenever banks_idle is 0.
- R10: sr_gnt with sr_req sets in_self_refresh, clears owed_cnt, and holds ref_req, cmd_ok, rd_ok and term_en at 0; the interval timer does not fire while in self refresh.
- R11: After a one-cycle sr_exit pulse, cmd_ok first reads 1 cfg_xsnr+1 cycles later, and rd_ok and term_en first read 1 cfg_xsrd+1 cycles later.
- R12: The interval timer restarts a full period on the sr_exit cycle, so the first owed refresh appears cfg_refi+1 cycles after the pulse cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_refi | input | CNT_W | Normal refresh interval in cycles |
| cfg_xsnr | input | CNT_W | Exit wait before non-read commands |
| cfg_xsrd | input | CNT_W | Exit wait before reads and termination |
| cfg_aofd | input | CNT_W | Termination-off wait before entry |
| high_temp | input | 1 | Case temperature above threshold |
| banks_idle | input | 1 | All banks precharged |
| sr_enter | input | 1 | Request to enter self refresh |
| sr_exit | input | 1 | Self-refresh exit command issued |
| ref_gnt | input | 1 | Arbiter accepts a refresh |
| sr_gnt | input | 1 | Arbiter issued the self-refresh entry command |
| ref_req | output | 1 | Refresh requested |
| ref_urgent | output | 1 | Debt at its limit |
| owed_cnt | output | OWED_W | Refreshes owed |
| hot_sr_en | output | 1 | High-temperature self-refresh option select |
| sr_req | output | 1 | Self-refresh entry command requested |
| in_self_refresh | output | 1 | Device in self refresh |
| cmd_ok | output | 1 | Non-read commands allowed |
| rd_ok | output | 1 | Reads allowed |
| term_en | output | 1 | Termination may be enabled |

## Verification
The bench switches the temperature input in the cycle right after a reload, so a design that applied the change at once would show a half-length or a double-length interval where the full old one is expected. It aligns a grant with a timer firing, where a design that let one event win would move the debt by one. It holds the debt at its limit past another firing, so a design that wraps would read 0. It times both exit releases to the exact cycle, so a design that shares one wait or counts one cycle off would release reads or other commands at the wrong time. It also drops bank idle while the entry request is pending, so a design that latched the request would keep it raised.

// File: rtl/refsched_pkg.sv
package refsched_pkg;

    typedef enum logic [2:0] {
        ST_RUN,
        ST_TOFF,
        ST_ENTRY,
        ST_IN,
        ST_EXIT
    } sr_state_e;

    typedef struct packed {
        logic cmd_ok;
        logic rd_ok;
        logic term_en;
    } gate_t;

    // Reload value for a down counter whose period is the chosen interval.
    function automatic int unsigned reload_val(int unsigned refi, logic hot);
        int unsigned per;
        per = hot ? (refi >> 1) : refi;
        return (per == 0) ? 0 : per - 1;
    endfunction

endpackage

// File: rtl/refsched_interval.sv
module refsched_interval
    import refsched_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_refi,
    input  logic             high_temp,
    input  logic             run_en,
    input  logic             restart,
    output logic             tick,
    output logic             hot_mode
);
    logic [CNT_W-1:0] cnt;

    assign tick = run_en && !restart && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= CNT_W'(reload_val(32'(cfg_refi), 1'b0));
            hot_mode <= 1'b0;
        end else if (restart || tick) begin
            cnt      <= CNT_W'(reload_val(32'(cfg_refi), high_temp));
            hot_mode <= high_temp;
        end else if (run_en) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/refsched_owed.sv
module refsched_owed #(
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = $clog2(MAX_OWED + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              take,
    input  logic              clear,
    output logic [OWED_W-1:0] owed
);
    localparam logic [OWED_W-1:0] LIMIT = OWED_W'(MAX_OWED);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            owed <= '0;
        end else begin
            unique case ({tick, take})
                2'b10:   if (owed != LIMIT) owed <= owed + 1'b1;
                2'b01:   owed <= owed - 1'b1;
                default: owed <= owed;
            endcase
        end
    end
endmodule

// File: rtl/refsched_srfsm.sv
module refsched_srfsm
    import refsched_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] cfg_xsnr,
    input  logic [CNT_W-1:0] cfg_xsrd,
    input  logic [CNT_W-1:0] cfg_aofd,
    input  logic             banks_idle,
    input  logic             sr_enter,
    input  logic             sr_exit,
    input  logic             sr_gnt,
    output sr_state_e        state,
    output logic             sr_req,
    output logic             sr_taken,
    output logic             restart,
    output gate_t            gate
);
    logic [CNT_W-1:0] wait_a;
    logic [CNT_W-1:0] wait_b;

    assign sr_req   = (state == ST_ENTRY) && banks_idle;
    assign sr_taken = sr_req && sr_gnt;
    assign restart  = (state == ST_IN) && sr_exit;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_RUN;
            wait_a <= '0;
            wait_b <= '0;
        end else begin
            unique case (state)
                ST_RUN: if (sr_enter) begin
                    state  <= ST_TOFF;
                    wait_a <= cfg_aofd;
                end
                ST_TOFF: begin
                    if (wait_a == '0) state <= ST_ENTRY;
                    else              wait_a <= wait_a - 1'b1;
                end
                ST_ENTRY: if (sr_taken) state <= ST_IN;
                ST_IN: if (sr_exit) begin
                    state  <= ST_EXIT;
                    wait_a <= cfg_xsnr;
                    wait_b <= cfg_xsrd;
                end
                ST_EXIT: begin
                    if (wait_a != '0) wait_a <= wait_a - 1'b1;
                    if (wait_b != '0) wait_b <= wait_b - 1'b1;
                    if (wait_a == '0 && wait_b == '0) state <= ST_RUN;
                end
                default: state <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        unique case (state)
            ST_RUN:            gate = '{cmd_ok: 1'b1, rd_ok: 1'b1, term_en: 1'b1};
            ST_TOFF, ST_ENTRY: gate = '{cmd_ok: 1'b1, rd_ok: 1'b1, term_en: 1'b0};
            ST_EXIT:           gate = '{cmd_ok: (wait_a == '0), rd_ok: (wait_b == '0),
                                        term_en: (wait_b == '0)};
            default:           gate = '{cmd_ok: 1'b0, rd_ok: 1'b0, term_en: 1'b0};
        endcase
    end
endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
    import refsched_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = $clog2(MAX_OWED + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [CNT_W-1:0]  cfg_refi,
    input  logic [CNT_W-1:0]  cfg_xsnr,
    input  logic [CNT_W-1:0]  cfg_xsrd,
    input  logic [CNT_W-1:0]  cfg_aofd,
    input  logic              high_temp,
    input  logic              banks_idle,
    input  logic              sr_enter,
    input  logic              sr_exit,
    input  logic              ref_gnt,
    input  logic              sr_gnt,
    output logic              ref_req,
    output logic              ref_urgent,
    output logic [OWED_W-1:0] owed_cnt,
    output logic              hot_sr_en,
    output logic              sr_req,
    output logic              in_self_refresh,
    output logic              cmd_ok,
    output logic              rd_ok,
    output logic              term_en
);
    localparam logic [OWED_W-1:0] LIMIT = OWED_W'(MAX_OWED);

    sr_state_e state;
    gate_t     gate;
    logic      tick;
    logic      restart;
    logic      sr_taken;
    logic      take;

    refsched_srfsm #(.CNT_W(CNT_W)) u_fsm (
        .clk        (clk),
        .rst        (rst),
        .cfg_xsnr   (cfg_xsnr),
        .cfg_xsrd   (cfg_xsrd),
        .cfg_aofd   (cfg_aofd),
        .banks_idle (banks_idle),
        .sr_enter   (sr_enter),
        .sr_exit    (sr_exit),
        .sr_gnt     (sr_gnt),
        .state      (state),
        .sr_req     (sr_req),
        .sr_taken   (sr_taken),
        .restart    (restart),
        .gate       (gate)
    );

    refsched_interval #(.CNT_W(CNT_W)) u_timer (
        .clk       (clk),
        .rst       (rst),
        .cfg_refi  (cfg_refi),
        .high_temp (high_temp),
        .run_en    (state != ST_IN),
        .restart   (restart),
        .tick      (tick),
        .hot_mode  (hot_sr_en)
    );

    refsched_owed #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_owed (
        .clk   (clk),
        .rst   (rst),
        .tick  (tick),
        .take  (take),
        .clear (sr_taken),
        .owed  (owed_cnt)
    );

    assign ref_req         = (state == ST_RUN) && (owed_cnt != '0);
    assign take            = ref_req && ref_gnt;
    assign ref_urgent      = ref_req && (owed_cnt == LIMIT);
    assign in_self_refresh = (state == ST_IN);
    assign cmd_ok          = gate.cmd_ok;
    assign rd_ok           = gate.rd_ok;
    assign term_en         = gate.term_en;
endmodule

// File: rtl/refsched_chk.sv
module refsched_chk #(
    parameter int MAX_OWED = 8,
    parameter int OWED_W   = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              banks_idle,
    input logic              ref_req,
    input logic              ref_urgent,
    input logic [OWED_W-1:0] owed_cnt,
    input logic              sr_req,
    input logic              in_self_refresh,
    input logic              cmd_ok,
    input logic              rd_ok,
    input logic              term_en
);
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        owed_cnt <= OWED_W'(MAX_OWED));

    a_r6_urgent_has_req: assert property (@(posedge clk) disable iff (rst)
        ref_urgent |-> ref_req);

    a_r9_entry_needs_idle: assert property (@(posedge clk) disable iff (rst)
        sr_req |-> banks_idle);

    a_r10_blocked_in_sr: assert property (@(posedge clk) disable iff (rst)
        in_self_refresh |-> (!ref_req && !cmd_ok && !rd_ok && !term_en));

    a_r10_debt_cleared: assert property (@(posedge clk) disable iff (rst)
        $rose(in_self_refresh) |-> (owed_cnt == '0));

    a_r11_term_after_read: assert property (@(posedge clk) disable iff (rst)
        term_en |-> rd_ok);
endmodule

bind refresh_sched refsched_chk #(.MAX_OWED(MAX_OWED), .OWED_W(OWED_W)) u_chk (
    .clk             (clk),
    .rst             (rst),
    .banks_idle      (banks_idle),
    .ref_req         (ref_req),
    .ref_urgent      (ref_urgent),
    .owed_cnt        (owed_cnt),
    .sr_req          (sr_req),
    .in_self_refresh (in_self_refresh),
    .cmd_ok          (cmd_ok),
    .rd_ok           (rd_ok),
    .term_en         (term_en)
);

// File: tb/refresh_sched_test.sv
module refresh_sched_test;
    localparam int CNT_W = 16;
    localparam int MAXO  = 8;
    localparam int OW    = 4;
    localparam int P     = 40;
    localparam int XSNR  = 6;
    localparam int XSRD  = 20;
    localparam int AOFD  = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic high_temp = 1'b0, banks_idle = 1'b1, sr_enter = 1'b0, sr_exit = 1'b0;
    logic ref_gnt = 1'b0, sr_gnt = 1'b0;
    logic ref_req, ref_urgent, hot_sr_en, sr_req, in_self_refresh, cmd_ok, rd_ok, term_en;
    logic [OW-1:0] owed_cnt;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    refresh_sched #(.CNT_W(CNT_W), .MAX_OWED(MAXO)) uut (
        .clk(clk), .rst(rst),
        .cfg_refi(CNT_W'(P)), .cfg_xsnr(CNT_W'(XSNR)),
        .cfg_xsrd(CNT_W'(XSRD)), .cfg_aofd(CNT_W'(AOFD)),
        .high_temp(high_temp), .banks_idle(banks_idle),
        .sr_enter(sr_enter), .sr_exit(sr_exit),
        .ref_gnt(ref_gnt), .sr_gnt(sr_gnt),
        .ref_req(ref_req), .ref_urgent(ref_urgent), .owed_cnt(owed_cnt),
        .hot_sr_en(hot_sr_en), .sr_req(sr_req), .in_self_refresh(in_self_refresh),
        .cmd_ok(cmd_ok), .rd_ok(rd_ok), .term_en(term_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_inc(output int n);
        int prev;
        prev = owed_cnt;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (owed_cnt == prev && n < 500);
    endtask

    task automatic drain();
        while (ref_req) begin
            ref_gnt = 1'b1;
            @(negedge clk);
        end
        ref_gnt = 1'b0;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "owed_cnt", owed_cnt, 0);
        chk("R1", "ref_req", ref_req, 0);
        chk("R1", "sr_req", sr_req, 0);
        chk("R1", "in_self_refresh", in_self_refresh, 0);
        chk("R1", "hot_sr_en", hot_sr_en, 0);
        chk("R1", "cmd/rd/term", {cmd_ok, rd_ok, term_en}, 3'b111);
    endtask

    task automatic t_normal_period();
        int n;
        wait_inc(n);
        wait_inc(n); chk("R2", "normal interval", n, P);
        wait_inc(n); chk("R2", "normal interval again", n, P);
    endtask

    task automatic t_grant();
        int n, o;
        wait_inc(n);
        chk("R5", "ref_req with debt", ref_req, 1);
        o = owed_cnt;
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk("R5", "grant decrements", owed_cnt, o - 1);
        repeat (P - 2) @(negedge clk);
        o = owed_cnt;
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk("R5", "grant with firing", owed_cnt, o);
    endtask

    task automatic t_ignore_grant();
        int n;
        wait_inc(n);
        drain();
        chk("R5", "no req at zero", ref_req, 0);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        @(negedge clk);
        chk("R7", "stray grant ignored", owed_cnt, 0);
    endtask

    task automatic t_temp_switch();
        int n;
        wait_inc(n);
        high_temp = 1'b1;
        wait_inc(n); chk("R4", "old interval completes", n, P);
        chk("R4", "hot flag at reload", hot_sr_en, 1);
        wait_inc(n); chk("R3", "halved interval", n, P / 2);
        wait_inc(n); chk("R3", "halved interval again", n, P / 2);
        chk("R3", "hot flag", hot_sr_en, 1);
        high_temp = 1'b0;
        wait_inc(n); chk("R4", "hot interval completes", n, P / 2);
        chk("R4", "hot flag cleared at reload", hot_sr_en, 0);
        wait_inc(n); chk("R2", "back to normal", n, P);
        drain();
    endtask

    task automatic t_saturate();
        int n;
        for (int i = 0; i < 12 && owed_cnt != MAXO; i++) wait_inc(n);
        chk("R6", "reached limit", owed_cnt, MAXO);
        chk("R6", "urgent at limit", ref_urgent, 1);
        repeat (P + 10) @(negedge clk);
        chk("R6", "saturated", owed_cnt, MAXO);
        ref_gnt = 1'b1;
        @(negedge clk);
        ref_gnt = 1'b0;
        chk("R6", "below limit", owed_cnt, MAXO - 1);
        chk("R6", "urgent cleared", ref_urgent, 0);
    endtask

    task automatic t_sr_entry();
        int n;
        wait_inc(n);
        drain();
        sr_enter = 1'b1;
        @(negedge clk);
        sr_enter = 1'b0;
        chk("R8", "term off next cycle", term_en, 0);
        repeat (AOFD) @(negedge clk);
        chk("R8", "sr_req not yet", sr_req, 0);
        @(negedge clk);
        chk("R8", "sr_req after aofd", sr_req, 1);
        banks_idle = 1'b0;
        @(negedge clk);
        chk("R9", "sr_req drops when busy", sr_req, 0);
        repeat (5) @(negedge clk);
        chk("R9", "sr_req stays low", sr_req, 0);
        banks_idle = 1'b1;
        @(negedge clk);
        chk("R9", "sr_req back when idle", sr_req, 1);
        sr_gnt = 1'b1;
        @(negedge clk);
        sr_gnt = 1'b0;
        chk("R10", "in self refresh", in_self_refresh, 1);
        chk("R10", "debt cleared", owed_cnt, 0);
        chk("R10", "all blocked", {ref_req, cmd_ok, rd_ok, term_en}, 0);
        repeat (3 * P) @(negedge clk);
        chk("R10", "no firing in self refresh", owed_cnt, 0);
    endtask

    task automatic t_sr_exit();
        int first;
        first = 0;
        sr_exit = 1'b1;
        for (int j = 1; j <= 200 && first == 0; j++) begin
            @(negedge clk);
            sr_exit = 1'b0;
            if (j == 1)        chk("R11", "left self refresh", in_self_refresh, 0);
            if (j == XSNR)     chk("R11", "cmd blocked", cmd_ok, 0);
            if (j == XSNR + 1) chk("R11", "cmd released", cmd_ok, 1);
            if (j == XSNR + 1) chk("R11", "read still blocked", rd_ok, 0);
            if (j == XSRD)     chk("R11", "read/term blocked", {rd_ok, term_en}, 0);
            if (j == XSRD + 1) chk("R11", "read/term released", {rd_ok, term_en}, 3);
            if (owed_cnt != 0) first = j;
        end
        chk("R12", "first firing after exit", first, P + 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_normal_period();
        t_grant();
        t_ignore_grant();
        t_temp_switch();
        t_saturate();
        t_sr_entry();
        t_sr_exit();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule